// File: doc/BRIEF.md
# Two-Stage Byte Serializer

This block turns a byte-wide transmit bus into a single-bit stream. It works in one serial clock domain. An upstream byte clock is represented by a one-cycle capture strobe. When that strobe is present, an input holding register takes the byte on the bus. A free-running phase counter divides the serial clock by the byte width. Its last phase produces a load strobe. On that strobe a separate shift register takes its parallel word from the holding register and nothing else.

The shift register puts one bit on the line per serial clock, most significant bit first. A new word is loaded on the edge that would otherwise shift out the last bit of the previous word, so there is never an idle slot between words. If no new byte was captured since the last load, the holding register still has its old contents and that byte is sent again. The load strobe is also driven out. Upstream logic can use it as a byte-rate reference and present data at a fixed phase with enough margin.

Top module: `byte_serializer`

## Requirements
- R1: While `rst_i` is high, and after its release until the first load strobe, `ser_o` is 0 and `load_stb_o` is 0. Reset also clears the holding register to 0.
- R2: `load_stb_o` is high for exactly one cycle in every 8. Its first high cycle follows the 7th rising edge that samples `rst_i` low.
- R3: The holding register changes only on a rising edge where `cap_stb_i` is 1. Values on `data_i` in other cycles do not reach `ser_o`.
- R4: A rising edge with `load_stb_o` high loads the shift register with the holding register contents from before that edge. If a byte is captured on that same edge, it is sent at the following load.
- R5: Bit 7 of each byte appears on `ser_o` first, then bits 6 down to 0, each for one cycle.
- R6: Consecutive bytes follow each other with no gap: the first bit of the next byte comes in the cycle right after the last bit of the previous one.
- R7: A byte captured on the rising edge four edges before a load edge shows its bit 7 on `ser_o` right after that load edge. This is the fifth rising edge, counting the capture edge as the first.
- R8: If no capture happens between two loads, the byte loaded at the first is sent again in full at the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| cap_stb_i | input | 1 | One-cycle marker of the upstream byte clock edge; captures `data_i` |
| data_i | input | 8 | Parallel transmit byte |
| ser_o | output | 1 | Serial data, one bit per clock, MSB first |
| load_stb_o | output | 1 | Byte-boundary strobe, high in the cycle whose closing edge loads the shift register |

## Verification
The hardest case to reach from the ports is a capture that lands on the same edge as a load. In that case the old byte must go out and the new one must wait a full byte period. The stimulus tracks the load phase in its own model and fires the capture strobe in the cycle where the load strobe is high. Beyond that case, bytes are captured mid-period, idle periods are left with garbage on the data bus to show retransmission, and a reset in mid-stream restarts the phase.

// File: rtl/ser_pkg.sv
package ser_pkg;

    parameter int unsigned BYTE_W = 8;
    localparam int unsigned PHASE_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [PHASE_W-1:0] phase_t;

    // capture request from the upstream byte-clock domain
    typedef struct packed {
        logic  stb;
        byte_t data;
    } cap_req_t;

    // parallel load request towards the shifter
    typedef struct packed {
        logic  load;
        byte_t word;
    } load_req_t;

    localparam phase_t LAST_PHASE = phase_t'(BYTE_W - 1);

    function automatic phase_t phase_step(input phase_t p);
        return (p == LAST_PHASE) ? '0 : phase_t'(p + 1'b1);
    endfunction

endpackage

// File: rtl/ser_phase_gen.sv
module ser_phase_gen
    import ser_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    output logic load_stb_o
);

    phase_t ph_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q <= '0;
        end else begin
            ph_q <= phase_step(ph_q);
        end
    end

    // last phase of the byte period: its closing edge reloads the shifter
    assign load_stb_o = (ph_q == LAST_PHASE);

endmodule

// File: rtl/ser_cap_reg.sv
module ser_cap_reg
    import ser_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  cap_req_t req_i,
    output byte_t    word_o
);

    byte_t word_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            word_q <= '0;
        end else if (req_i.stb) begin
            word_q <= req_i.data;
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg
    import ser_pkg::*;
#(
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  load_req_t req_i,
    output logic      ser_o
);

    byte_t sh_q;
    byte_t sh_next;

    generate
        if (MSB_FIRST) begin : g_msb
            assign sh_next = {sh_q[BYTE_W-2:0], 1'b0};
            assign ser_o   = sh_q[BYTE_W-1];
        end else begin : g_lsb
            assign sh_next = {1'b0, sh_q[BYTE_W-1:1]};
            assign ser_o   = sh_q[0];
        end
    endgenerate

    // zeros are shifted in, so the line idles low until the first load
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_q <= '0;
        end else if (req_i.load) begin
            sh_q <= req_i.word;
        end else begin
            sh_q <= sh_next;
        end
    end

endmodule

// File: rtl/byte_serializer.sv
module byte_serializer
    import ser_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cap_stb_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              ser_o,
    output logic              load_stb_o
);

    logic      load_stb;
    byte_t     held_word;
    cap_req_t  cap_req;
    load_req_t load_req;

    assign cap_req.stb  = cap_stb_i;
    assign cap_req.data = data_i;

    ser_phase_gen u_phase (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_stb_o (load_stb)
    );

    ser_cap_reg u_cap (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .req_i  (cap_req),
        .word_o (held_word)
    );

    assign load_req.load = load_stb;
    assign load_req.word = held_word;

    ser_shift_reg #(
        .MSB_FIRST (1'b1)
    ) u_shift (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .req_i (load_req),
        .ser_o (ser_o)
    );

    assign load_stb_o = load_stb;

endmodule

// File: rtl/byte_serializer_chk.sv
module byte_serializer_chk
    import ser_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              cap_stb_i,
    input logic [BYTE_W-1:0] data_i,
    input logic              ser_o,
    input logic              load_stb_o
);

    localparam logic [PHASE_W:0] GAP_LAST = (PHASE_W+1)'(BYTE_W - 1);

    logic [PHASE_W:0] gap_q;
    byte_t            seen_byte_q;
    logic             seen_load_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gap_q       <= '0;
            seen_byte_q <= '0;
            seen_load_q <= 1'b0;
        end else begin
            gap_q <= load_stb_o ? '0 : gap_q + 1'b1;
            if (cap_stb_i) seen_byte_q <= data_i;
            if (load_stb_o) seen_load_q <= 1'b1;
        end
    end

    p_quiet_before_load_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        !seen_load_q |-> !ser_o);

    p_strobe_spacing_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        load_stb_o |-> gap_q == GAP_LAST);

    p_strobe_due_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        gap_q == GAP_LAST |-> load_stb_o);

    p_collide_keeps_old_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_stb_o && cap_stb_i) |=> ser_o == $past(seen_byte_q[BYTE_W-1]));

    p_msb_on_load_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        load_stb_o |=> ser_o == $past(seen_byte_q[BYTE_W-1]));

endmodule

bind byte_serializer byte_serializer_chk chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cap_stb_i  (cap_stb_i),
    .data_i     (data_i),
    .ser_o      (ser_o),
    .load_stb_o (load_stb_o)
);

// File: tb/byte_serializer_tb_top.sv
`timescale 1ns/1ps
module byte_serializer_tb_top;
    import ser_pkg::*;

    localparam int BW = BYTE_W;
    localparam realtime WD_NS = 200000 * 4.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cap = 1'b0;
    logic [BW-1:0] data = '0;
    logic ser, lstb;

    int n_chk = 0;
    int n_err = 0;
    bit chk_en = 1'b0;

    always #2 clk = ~clk;

    byte_serializer dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .cap_stb_i  (cap),
        .data_i     (data),
        .ser_o      (ser),
        .load_stb_o (lstb)
    );

    // behavioural reference: a bit queue filled at each byte boundary
    bit          m_q[$];
    logic [BW-1:0] m_hold = '0;
    int          m_cnt = 0;
    logic        m_exp = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            m_hold = '0;
            m_q.delete();
            m_exp = 1'b0;
        end else begin
            if (m_cnt == BW-1)
                for (int i = BW-1; i >= 0; i--) m_q.push_back(m_hold[i]);
            if (cap) m_hold = data;
            m_exp = (m_q.size() > 0) ? m_q.pop_front() : 1'b0;
            m_cnt = (m_cnt + 1) % BW;
        end
    end

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %0b exp %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // every cycle: serial stream (R6) and strobe phase (R2) against the model
    always @(negedge clk) begin
        if (chk_en) begin
            chk("R6 stream", ser, m_exp);
            chk("R2 strobe", lstb, (m_cnt == BW-1) ? 1'b1 : 1'b0);
        end
    end

    logic [BW-1:0] last_b = '0;

    task automatic wait_phase(input int v);
        do @(negedge clk); while (m_cnt != v);
    endtask

    // capture at phase 3, four edges ahead of the load edge
    task automatic send(input logic [BW-1:0] b);
        wait_phase(3);
        cap = 1'b1;
        data = b;
        @(negedge clk);
        cap = 1'b0;
        data = ~b ^ 8'h5C;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R7 latency", ser, b[BW-1]);
        for (int i = BW-2; i >= 0; i--) begin
            @(negedge clk);
            data = data + 8'h3B;
            chk("R5 order", ser, b[i]);
        end
        last_b = b;
    endtask

    task automatic reset_and_restart();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 reset ser", ser, 1'b0);
        chk("R1 reset strobe", lstb, 1'b0);
        rst = 1'b0;
        for (int k = 1; k <= BW-1; k++) begin
            @(negedge clk);
            chk("R2 first strobe", lstb, (k == BW-1) ? 1'b1 : 1'b0);
            chk("R1 idle low", ser, 1'b0);
        end
        last_b = '0;
    endtask

    initial begin
        #(WD_NS);
        n_err++;
        $display("FAIL watchdog R6 got running exp finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_en = 1'b1;
        chk("R1 reset ser", ser, 1'b0);
        chk("R1 reset strobe", lstb, 1'b0);
        rst = 1'b0;
        for (int k = 1; k <= BW-1; k++) begin
            @(negedge clk);
            chk("R2 first strobe", lstb, (k == BW-1) ? 1'b1 : 1'b0);
            chk("R1 idle low", ser, 1'b0);
        end

        send(8'hA5);
        send(8'hFF);
        send(8'h00);
        send(8'h81);
        send(8'h3C);
        send(8'h5A);

        // idle: no capture, garbage on the bus, same byte again (R8, R3)
        wait_phase(BW-1);
        data = 8'hE7;
        @(negedge clk);
        chk("R8 resend", ser, last_b[BW-1]);
        for (int i = BW-2; i >= 0; i--) begin
            data = data ^ 8'hFF;
            @(negedge clk);
            chk("R3 ignore data", ser, last_b[i]);
        end

        // capture on the load edge (R4)
        wait_phase(BW-1);
        cap = 1'b1;
        data = 8'hC3;
        @(negedge clk);
        cap = 1'b0;
        data = 8'h11;
        chk("R4 old byte", ser, last_b[BW-1]);
        wait_phase(BW-1);
        @(negedge clk);
        chk("R4 new byte", ser, 1'b1);
        last_b = 8'hC3;

        send(8'h69);
        send(8'h96);

        reset_and_restart();
        send(8'hB4);
        send(8'h01);

        repeat (BW) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule